// File: doc/BRIEF.md
# Recursive Adder-Tree Population Counter

This block is a purely combinational population counter. It takes a vector of single-bit lines and returns, in binary, how many of them are high. It serves as a building block inside multipliers, multi-operand adders and match-count logic, where a count of set flags is needed within the same cycle.

The tree grows in levels. Level one is the raw input bits. Each later level pairs two counters from the level below and merges their results with an adder. A spare input line drives that adder's carry-in, so a level built from two k-input counters counts 2k+1 lines. The first merge level is a row of full adders, each acting as a three-line counter. When the input count is not one less than a power of two, the tree is sized for the next such count and the missing lines are tied low. A parameter selects how the merges from the second level upward are built. They can be ripple-carry chains of full-adder cells, or lookup-table adders whose contents are computed at elaboration.

Top module: `tree_popcount`

## Requirements
- R1: For the default width of 15 lines in ripple mode, `countOut` equals the number of ones on `inBits` for every one of the 32768 input patterns.
- R2: With every input line low, `countOut` is 0.
- R3: With every input line high, `countOut` equals the parameter `N`.
- R4: `countOut`, read as an unsigned number, never exceeds `N`.
- R5: Bit 0 of `countOut` equals the XOR of all input lines.
- R6: With the table-merge option enabled (`USE_TABLE`=1), the count is identical to the ones count for every one of the 32768 patterns of a 15-line instance.
- R7: An `N` that is not one less than a power of two (20 lines in ripple mode, 16 lines in table mode) counts correctly on random patterns. The padded positions add nothing.
- R8: A single high line gives a count of exactly 1 at every input position, including the positions that feed merge carry-ins.
- R9: The output is 1 + floor(log2 N) bits wide. For N = 16 it is 5 bits, and all ones reads as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inBits | input | N | Lines to be counted |
| countOut | output | 1+floor(log2 N) | Unsigned binary count of high lines |

## Verification
Two things can land on the same merge cell at once: a spare line entering as carry-in, and a carry rippling up from the operand bits. If either is mishandled, the count is off by a power of two. All-ones patterns and the exhaustive sweep force both together at every level, and each result is compared against a ones count that the bench computes itself. Walking single-one patterns isolate each carry-in line by itself. Random wide vectors exercise the padded trees against the same independent reference.

// File: rtl/popc_pkg.sv
`timescale 1ns/1ps
package popc_pkg;

  // Number of output bits needed to hold counts 0..n: 1 + floor(log2 n)
  function automatic int countWidth(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  // Lines in a fully populated tree of the given depth
  function automatic int paddedLines(input int depth);
    return (1 << depth) - 1;
  endfunction

  // Number of merge cells on a level (level 2 .. depth)
  function automatic int cellsOnLevel(input int depth, input int lvl);
    return 1 << (depth - lvl);
  endfunction

  // First padded-input index used as a carry-in on a level.
  // Leaves take the low half; each level's spares follow in turn.
  function automatic int spareBase(input int depth, input int lvl);
    return (1 << depth) - (1 << (depth - lvl + 1));
  endfunction

endpackage

// File: rtl/full_adder_cell.sv
`timescale 1ns/1ps
module full_adder_cell (
  input  logic bitA,
  input  logic bitB,
  input  logic bitC,
  output logic sumBit,
  output logic carryBit
);
  assign sumBit   = bitA ^ bitB ^ bitC;
  assign carryBit = (bitA & bitB) | (bitC & (bitA ^ bitB));
endmodule

// File: rtl/ripple_merge.sv
`timescale 1ns/1ps
module ripple_merge #(
  parameter int W = 2
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W:0]   total
);
  logic [W:0]   chain;
  logic [W-1:0] sums;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    full_adder_cell u_fa (
      .bitA    (opA[i]),
      .bitB    (opB[i]),
      .bitC    (chain[i]),
      .sumBit  (sums[i]),
      .carryBit(chain[i+1])
    );
  end

  assign total = {chain[W], sums};
endmodule

// File: rtl/table_merge.sv
`timescale 1ns/1ps
module table_merge #(
  parameter int W = 2
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W:0]   total
);
  localparam int IDXW  = 2 * W + 1;
  localparam int DEPTH = 1 << IDXW;
  localparam int WORDW = W + 1;

  // Entry e holds the sum of its index fields {a, b, cin}
  function automatic logic [DEPTH*WORDW-1:0] buildRom();
    logic [DEPTH*WORDW-1:0] rom;
    int a, b, c;
    rom = '0;
    for (int e = 0; e < DEPTH; e++) begin
      a = (e >> (W + 1)) & ((1 << W) - 1);
      b = (e >> 1) & ((1 << W) - 1);
      c = e & 1;
      rom[e*WORDW +: WORDW] = WORDW'(a + b + c);
    end
    return rom;
  endfunction

  localparam logic [DEPTH*WORDW-1:0] ROM = buildRom();

  logic [IDXW-1:0] idx;
  assign idx   = {opA, opB, carryIn};
  assign total = ROM[int'(idx)*WORDW +: WORDW];
endmodule

// File: rtl/popc_tree.sv
`timescale 1ns/1ps
module popc_tree
  import popc_pkg::*;
#(
  parameter int N         = 15,
  parameter bit USE_TABLE = 1'b0,
  localparam int M        = countWidth(N)
) (
  input  logic [N-1:0] inBits,
  output logic [M-1:0] countOut
);
  localparam int DEPTH = M;
  localparam int P     = paddedLines(DEPTH);

  logic [P-1:0] padBits;

  if (P > N) begin : g_pad
    assign padBits = {{(P-N){1'b0}}, inBits};
  end else begin : g_nopad
    assign padBits = inBits;
  end

  for (genvar l = 2; l <= DEPTH; l++) begin : g_lvl
    localparam int CNT  = cellsOnLevel(DEPTH, l);
    localparam int W    = l - 1;
    localparam int BASE = spareBase(DEPTH, l);

    logic [l-1:0] sumOut [CNT];

    for (genvar k = 0; k < CNT; k++) begin : g_cell
      logic [W-1:0] opA, opB;
      logic         spare;

      if (l == 2) begin : g_leaf
        assign opA = padBits[2*k];
        assign opB = padBits[2*k+1];
      end else begin : g_inner
        assign opA = g_lvl[l-1].sumOut[2*k];
        assign opB = g_lvl[l-1].sumOut[2*k+1];
      end

      assign spare = padBits[BASE + k];

      if (USE_TABLE && W >= 2) begin : g_tab
        table_merge #(.W(W)) u_merge (
          .opA(opA), .opB(opB), .carryIn(spare), .total(sumOut[k])
        );
      end else begin : g_rip
        ripple_merge #(.W(W)) u_merge (
          .opA(opA), .opB(opB), .carryIn(spare), .total(sumOut[k])
        );
      end
    end
  end

  assign countOut = g_lvl[DEPTH].sumOut[0];

  // R4 and R5 guarded at the tree output
  always_comb begin
    if (!$isunknown(inBits)) begin
      // R4
      count_bound_chk: assert (int'(countOut) <= N)
        else $error("count %0d above %0d", countOut, N);
      // R5
      count_parity_chk: assert (countOut[0] == ^inBits)
        else $error("count parity mismatch");
    end
  end
endmodule

// File: rtl/tree_popcount.sv
`timescale 1ns/1ps
module tree_popcount
  import popc_pkg::*;
#(
  parameter int N         = 15,
  parameter bit USE_TABLE = 1'b0,
  localparam int M        = countWidth(N)
) (
  input  logic [N-1:0] inBits,
  output logic [M-1:0] countOut
);
  popc_tree #(.N(N), .USE_TABLE(USE_TABLE)) u_tree (
    .inBits  (inBits),
    .countOut(countOut)
  );

  always_comb begin
    if (!$isunknown(inBits)) begin
      // R2
      zero_in_chk: assert (!(inBits == '0) || countOut == '0)
        else $error("nonzero count for empty input");
      // R3
      full_in_chk: assert (!(&inBits) || countOut == M'(N))
        else $error("all-ones count %0d", countOut);
    end
  end
endmodule

// File: tb/tree_popcount_tb.sv
`timescale 1ns/1ps
module tree_popcount_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [14:0] in15 = '0;
  logic [19:0] in20 = '0;
  logic [15:0] in16 = '0;
  logic [3:0]  cnt15, cnt15Tab;
  logic [4:0]  cnt20, cnt16;

  tree_popcount #(.N(15), .USE_TABLE(1'b0)) u_dut    (.inBits(in15), .countOut(cnt15));
  tree_popcount #(.N(15), .USE_TABLE(1'b1)) u_dutTab (.inBits(in15), .countOut(cnt15Tab));
  tree_popcount #(.N(20), .USE_TABLE(1'b0)) u_dut20  (.inBits(in20), .countOut(cnt20));
  tree_popcount #(.N(16), .USE_TABLE(1'b1)) u_dut16  (.inBits(in16), .countOut(cnt16));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [14:0] a, input logic [19:0] b, input logic [15:0] c);
    @(posedge clk);
    in15 = a; in20 = b; in16 = c;
    @(negedge clk);
  endtask

  task automatic testZeros();
    drive('0, '0, '0);
    check("R2 n15", int'(cnt15), 0);
    check("R2 n15tab", int'(cnt15Tab), 0);
    check("R2 n20", int'(cnt20), 0);
    check("R2 n16", int'(cnt16), 0);
  endtask

  task automatic testOnes();
    drive('1, '1, '1);
    check("R3 n15", int'(cnt15), 15);
    check("R3 n15tab", int'(cnt15Tab), 15);
    check("R3 n20", int'(cnt20), 20);
    check("R9 n16 all ones", int'(cnt16), 16);
    check("R9 width n16", $bits(cnt16), 5);
    check("R9 width n15", $bits(cnt15), 4);
  endtask

  task automatic testExhaustive();
    for (int p = 0; p < 32768; p++) begin
      drive(15'(p), '0, '0);
      check("R1 exhaustive", int'(cnt15), $countones(15'(p)));
      check("R6 table exhaustive", int'(cnt15Tab), $countones(15'(p)));
    end
  endtask

  task automatic testWalking();
    for (int i = 0; i < 20; i++) begin
      drive(i < 15 ? 15'(1) << i : '0, 20'(1) << i, i < 16 ? 16'(1) << i : '0);
      check("R8 walk n20", int'(cnt20), 1);
      if (i < 15) begin
        check("R8 walk n15", int'(cnt15), 1);
        check("R8 walk n15tab", int'(cnt15Tab), 1);
      end
      if (i < 16) check("R8 walk n16", int'(cnt16), 1);
    end
  endtask

  task automatic testRandomWide();
    for (int r = 0; r < 3000; r++) begin
      logic [19:0] v20;
      logic [15:0] v16;
      v20 = 20'($urandom);
      v16 = 16'($urandom);
      drive('0, v20, v16);
      check("R7 n20 random", int'(cnt20), $countones(v20));
      check("R7 n16 random", int'(cnt16), $countones(v16));
    end
  endtask

  task automatic testBoundParity();
    logic [19:0] pats [4];
    pats[0] = 20'hFFFFE;
    pats[1] = 20'hAAAAA;
    pats[2] = 20'h80001;
    pats[3] = 20'h7FFFF;
    foreach (pats[i]) begin
      drive('0, pats[i], '0);
      check("R4 bound n20", int'(cnt20 <= 5'd20), 1);
      check("R5 parity n20", int'(cnt20[0]), int'(^pats[i]));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testZeros();
    testOnes();
    testWalking();
    testBoundParity();
    testRandomWide();
    testExhaustive();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule